// File: doc/BRIEF.md
# Banked Register Address Pointer

This block keeps the register address pointer of a two-port I/O expander whose register file holds eleven pairs of registers, one member per port. A serial front end loads the pointer when a transfer names a register address, and then strobes once per transferred data byte. The block works out the next pointer value from two configuration inputs: a layout bit and a sequential-disable bit. It also decodes the current pointer into a physical register index and a valid flag, which the register file uses to select storage.

Two address layouts are supported. In the interleaved layout the A and B members of each pair sit next to each other. In the split layout all port-A registers form one block and all port-B registers form a second block at a fixed higher base. Sequential mode walks the pointer upward and wraps it to zero after the last register of the active layout. Byte mode behaves differently in the two layouts. In the split layout the pointer stays where it is. In the interleaved layout it swaps between the two members of its current pair, so that a master can poll both ports with no new address phase.

Top module: `regptr_bank_map`

## Requirements
- R1: While reset is asserted and after it is released, the pointer is 00h, so reg_idx is 0 and reg_valid is 1.
- R2: With bank_split=0, address 2n+p (pair n from 0 to 10, p=0 for port A and p=1 for port B) gives reg_idx = 2n+p with reg_valid=1. Addresses 16h and above give reg_valid=0. Pair order: direction, polarity, change-interrupt enable, compare default, interrupt control, configuration, pull-up, interrupt flag, capture, port value, output latch.
- R3: With bank_split=1, address n (0 to 0Ah) gives reg_idx = 2n and address 10h+n gives reg_idx = 2n+1, both with reg_valid=1.
- R4: With bank_split=1, addresses 0Bh to 0Fh and addresses 1Bh and above give reg_valid=0.
- R5: The configuration pair (pair 5) maps to one physical register. Addresses 0Ah and 0Bh with bank_split=0, and addresses 05h and 15h with bank_split=1, all give reg_idx=10.
- R6: With seq_off=0 and bank_split=0, each adv strobe adds one to the pointer. A pointer at 15h or above goes to 00h instead.
- R7: With seq_off=0 and bank_split=1, each adv strobe adds one to the pointer, passing through the unmapped gap. A pointer at 1Ah or above goes to 00h instead.
- R8: With seq_off=1 and bank_split=1, adv leaves the pointer unchanged.
- R9: With seq_off=1 and bank_split=0, each adv strobe swaps the pointer between the two members of its pair (it flips address bit 0). The starting member may be either one.
- R10: When ld_en and adv are high in the same cycle, the pointer takes ld_addr and the advance is dropped.
- R11: With ld_en and adv both low, the pointer holds even if bank_split or seq_off changes. Only the decoding follows bank_split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load the pointer from ld_addr |
| ld_addr | input | 8 | Register address from the serial front end |
| adv | input | 1 | One pulse per transferred data byte |
| bank_split | input | 1 | 0 = interleaved layout, 1 = split layout |
| seq_off | input | 1 | 0 = sequential mode, 1 = byte mode |
| reg_idx | output | 5 | Physical register index, 2*pair + port |
| reg_valid | output | 1 | Pointer addresses a mapped register |

## Verification
The hardest states to reach are the pointer positions that the decoded outputs do not show on their own. These are the walk through the unmapped gap of the split layout, and the wrap from a pointer that was loaded beyond the last register. The stimulus loads an address just before the gap and strobes adv across the whole gap up to the wrap, checking reg_valid low at every unmapped step. In byte mode in the interleaved layout, the toggle is started from a port-B member, so that a plain increment is told apart from a swap.

// File: rtl/regptr_pkg.sv
`timescale 1ns/1ps
package regptr_pkg;
   localparam int unsigned REG_PAIRS    = 11;
   localparam int unsigned CFG_PAIR_POS = 5;
   localparam int unsigned PORT_B_BASE  = 16;
   localparam int unsigned PTR_BITS     = 8;

   typedef enum logic [0:0] {
      PORT_A = 1'b0,
      PORT_B = 1'b1
   } port_e;
endpackage

// File: rtl/regptr_step.sv
`timescale 1ns/1ps
module regptr_step #(
   parameter int unsigned ADDR_W = regptr_pkg::PTR_BITS,
   parameter int unsigned PAIRS  = regptr_pkg::REG_PAIRS,
   parameter int unsigned B_BASE = regptr_pkg::PORT_B_BASE
) (
   input  logic [ADDR_W-1:0] cur_ptr,
   input  logic              split_sel,
   input  logic              byte_mode,
   output logic [ADDR_W-1:0] nxt_ptr
);
   localparam logic [ADDR_W-1:0] LAST_IL    = ADDR_W'(2 * PAIRS - 1);
   localparam logic [ADDR_W-1:0] LAST_SPLIT = ADDR_W'(B_BASE + PAIRS - 1);

   logic [ADDR_W-1:0] wrap_at;

   always_comb begin
      wrap_at = split_sel ? LAST_SPLIT : LAST_IL;
      if (byte_mode) begin
         if (split_sel) nxt_ptr = cur_ptr;
         else           nxt_ptr = {cur_ptr[ADDR_W-1:1], ~cur_ptr[0]};
      end else if (cur_ptr >= wrap_at) begin
         nxt_ptr = '0;
      end else begin
         nxt_ptr = cur_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/regptr_decode.sv
`timescale 1ns/1ps
module regptr_decode #(
   parameter int unsigned ADDR_W     = regptr_pkg::PTR_BITS,
   parameter int unsigned PAIRS      = regptr_pkg::REG_PAIRS,
   parameter int unsigned B_BASE     = regptr_pkg::PORT_B_BASE,
   parameter int unsigned CFG_PAIR   = regptr_pkg::CFG_PAIR_POS,
   parameter bit          CFG_SHARED = 1'b1,
   parameter int unsigned PAIR_W     = $clog2(PAIRS),
   parameter int unsigned IDX_W      = PAIR_W + 1
) (
   input  logic [ADDR_W-1:0] cur_ptr,
   input  logic              split_sel,
   output logic [IDX_W-1:0]  idx_o,
   output logic              valid_o
);
   import regptr_pkg::*;

   localparam logic [ADDR_W-1:0] IL_END    = ADDR_W'(2 * PAIRS);
   localparam logic [ADDR_W-1:0] A_END     = ADDR_W'(PAIRS);
   localparam logic [ADDR_W-1:0] B_START   = ADDR_W'(B_BASE);
   localparam logic [ADDR_W-1:0] B_END     = ADDR_W'(B_BASE + PAIRS);
   localparam logic [PAIR_W-1:0] CFG_CODE  = PAIR_W'(CFG_PAIR);

   logic [PAIR_W-1:0] pair;
   port_e             port;
   logic [IDX_W-1:0]  raw_idx;

   always_comb begin
      pair    = '0;
      port    = PORT_A;
      valid_o = 1'b0;
      if (!split_sel) begin
         valid_o = cur_ptr < IL_END;
         pair    = cur_ptr[PAIR_W:1];
         port    = port_e'(cur_ptr[0]);
      end else if (cur_ptr < A_END) begin
         valid_o = 1'b1;
         pair    = cur_ptr[PAIR_W-1:0];
         port    = PORT_A;
      end else if (cur_ptr >= B_START && cur_ptr < B_END) begin
         valid_o = 1'b1;
         pair    = cur_ptr[PAIR_W-1:0];
         port    = PORT_B;
      end
   end

   generate
      if (CFG_SHARED) begin : g_cfg_shared
         always_comb begin
            if (pair == CFG_CODE) raw_idx = {CFG_CODE, 1'b0};
            else                  raw_idx = {pair, port};
         end
      end else begin : g_cfg_split
         always_comb raw_idx = {pair, port};
      end
   endgenerate

   assign idx_o = valid_o ? raw_idx : '0;
endmodule

// File: rtl/regptr_bank_map.sv
`timescale 1ns/1ps
module regptr_bank_map #(
   parameter int unsigned ADDR_W     = regptr_pkg::PTR_BITS,
   parameter int unsigned PAIRS      = regptr_pkg::REG_PAIRS,
   parameter int unsigned B_BASE     = regptr_pkg::PORT_B_BASE,
   parameter int unsigned CFG_PAIR   = regptr_pkg::CFG_PAIR_POS,
   parameter bit          CFG_SHARED = 1'b1,
   parameter int unsigned IDX_W      = $clog2(PAIRS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              adv,
   input  logic              bank_split,
   input  logic              seq_off,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              reg_valid
);
   localparam int unsigned PAIR_W = $clog2(PAIRS);
   localparam logic [ADDR_W-1:0] LAST_IL    = ADDR_W'(2 * PAIRS - 1);
   localparam logic [ADDR_W-1:0] LAST_SPLIT = ADDR_W'(B_BASE + PAIRS - 1);
   localparam logic [ADDR_W-1:0] CFG_B_SPLIT = ADDR_W'(B_BASE + CFG_PAIR);

   generate
      if (B_BASE < (1 << PAIR_W) || (B_BASE & (B_BASE - 1)) != 0) begin : g_bad_base
         $error("B_BASE must be a power of two covering all pairs");
      end
      if (CFG_PAIR >= PAIRS) begin : g_bad_cfg
         $error("CFG_PAIR outside the pair range");
      end
      if (B_BASE + PAIRS > (1 << ADDR_W)) begin : g_bad_width
         $error("ADDR_W too narrow for the split layout");
      end
      if (IDX_W != PAIR_W + 1) begin : g_bad_idx
         $error("IDX_W must be one bit wider than the pair field");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_adv;

   regptr_step #(
      .ADDR_W (ADDR_W),
      .PAIRS  (PAIRS),
      .B_BASE (B_BASE)
   ) u_step (
      .cur_ptr   (ptr_q),
      .split_sel (bank_split),
      .byte_mode (seq_off),
      .nxt_ptr   (ptr_adv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (ld_en) ptr_q <= ld_addr;
      else if (adv)   ptr_q <= ptr_adv;
   end

   regptr_decode #(
      .ADDR_W     (ADDR_W),
      .PAIRS      (PAIRS),
      .B_BASE     (B_BASE),
      .CFG_PAIR   (CFG_PAIR),
      .CFG_SHARED (CFG_SHARED),
      .PAIR_W     (PAIR_W),
      .IDX_W      (IDX_W)
   ) u_decode (
      .cur_ptr   (ptr_q),
      .split_sel (bank_split),
      .idx_o     (reg_idx),
      .valid_o   (reg_valid)
   );

   // R10: load wins over a simultaneous advance
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> ptr_q == $past(ld_addr));

   // R11: no strobe, no movement
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !adv) |=> $stable(ptr_q));

   // R8: byte mode in the split layout
   a_r8_split_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && adv && seq_off && bank_split) |=> $stable(ptr_q));

   // R9: byte mode in the interleaved layout swaps pair members
   a_r9_pair_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && adv && seq_off && !bank_split) |=>
         (ptr_q[0] != $past(ptr_q[0])) && (ptr_q[ADDR_W-1:1] == $past(ptr_q[ADDR_W-1:1])));

   // R6: sequential wrap in the interleaved layout
   a_r6_il_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && adv && !seq_off && !bank_split && ptr_q >= LAST_IL) |=> ptr_q == '0);

   // R7: sequential wrap in the split layout
   a_r7_split_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && adv && !seq_off && bank_split && ptr_q >= LAST_SPLIT) |=> ptr_q == '0);

   // R5: both configuration addresses reach one register
   a_r5_cfg_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_split && ptr_q == CFG_B_SPLIT && CFG_SHARED) |-> reg_idx == IDX_W'(2 * CFG_PAIR));

   // R2: a decoded index never exceeds the physical register count
   a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |-> reg_idx < IDX_W'(2 * PAIRS));
endmodule

// File: tb/tb_regptr_bank_map.sv
`timescale 1ns/1ps
module tb_regptr_bank_map;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_en = 1'b0;
   logic [7:0] ld_addr = '0;
   logic       adv = 1'b0;
   logic       bank_split = 1'b0;
   logic       seq_off = 1'b0;
   logic [4:0] reg_idx;
   logic       reg_valid;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] m_ptr = '0;

   always #4 clk = ~clk;

   regptr_bank_map dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .adv(adv),
      .bank_split(bank_split), .seq_off(seq_off), .reg_idx(reg_idx), .reg_valid(reg_valid)
   );

   function automatic logic [5:0] expect_of(input logic [7:0] a, input logic b);
      int pair = 0;
      int port = 0;
      logic v = 1'b0;
      if (!b) begin
         if (a < 22) begin pair = a / 2; port = a % 2; v = 1'b1; end
      end else if (a < 11) begin
         pair = a; port = 0; v = 1'b1;
      end else if (a >= 16 && a < 27) begin
         pair = a - 16; port = 1; v = 1'b1;
      end
      if (!v) return 6'd0;
      if (pair == 5) return {1'b1, 5'd10};
      return {1'b1, 5'(pair * 2 + port)};
   endfunction

   function automatic logic [7:0] model_next(input logic [7:0] p, input logic b, input logic so);
      if (so) return b ? p : (p ^ 8'h01);
      if (!b) return (p >= 8'h15) ? 8'h00 : p + 8'h01;
      return (p >= 8'h1A) ? 8'h00 : p + 8'h01;
   endfunction

   task automatic check(input string req);
      logic [5:0] e;
      e = expect_of(m_ptr, bank_split);
      n_chk++;
      if (reg_valid !== e[5] || (e[5] && reg_idx !== e[4:0])) begin
         n_bad++;
         $display("FAIL %s: ptr=%02h bank=%0b got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                  req, m_ptr, bank_split, reg_valid, reg_idx, e[5], e[4:0]);
      end
   endtask

   task automatic step(input logic l, input logic [7:0] a, input logic s, input string req);
      @(negedge clk);
      ld_en = l; ld_addr = a; adv = s;
      @(posedge clk);
      #1;
      if (l) m_ptr = a;
      else if (s) m_ptr = model_next(m_ptr, bank_split, seq_off);
      ld_en = 1'b0; adv = 1'b0;
      check(req);
   endtask

   task automatic set_mode(input logic b, input logic so);
      @(negedge clk);
      bank_split = b; seq_off = so;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      m_ptr = '0;
      repeat (3) @(posedge clk);
      #1 check("R1");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 check("R1");
   endtask

   task automatic t_il_decode;
      set_mode(1'b0, 1'b0);
      for (int a = 0; a < 32; a++)
         step(1'b1, 8'(a), 1'b0, (a == 10 || a == 11) ? "R5" : "R2");
   endtask

   task automatic t_split_decode;
      set_mode(1'b1, 1'b0);
      for (int a = 0; a < 64; a++) begin
         if (a == 5 || a == 21) step(1'b1, 8'(a), 1'b0, "R5");
         else if ((a > 10 && a < 16) || a > 26) step(1'b1, 8'(a), 1'b0, "R4");
         else step(1'b1, 8'(a), 1'b0, "R3");
      end
   endtask

   task automatic t_seq_il;
      set_mode(1'b0, 1'b0);
      step(1'b1, 8'h13, 1'b0, "R6");
      for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, "R6");
      step(1'b1, 8'h1E, 1'b0, "R6");
      step(1'b0, 8'h00, 1'b1, "R6");
   endtask

   task automatic t_seq_split;
      set_mode(1'b1, 1'b0);
      step(1'b1, 8'h08, 1'b0, "R7");
      for (int i = 0; i < 21; i++) step(1'b0, 8'h00, 1'b1, "R7");
      step(1'b1, 8'h30, 1'b0, "R7");
      step(1'b0, 8'h00, 1'b1, "R7");
   endtask

   task automatic t_byte_split;
      set_mode(1'b1, 1'b1);
      step(1'b1, 8'h13, 1'b0, "R8");
      for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1, "R8");
      step(1'b1, 8'h02, 1'b0, "R8");
      step(1'b0, 8'h00, 1'b1, "R8");
   endtask

   task automatic t_byte_il;
      set_mode(1'b0, 1'b1);
      step(1'b1, 8'h12, 1'b0, "R9");
      for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1, "R9");
      step(1'b1, 8'h07, 1'b0, "R9");
      for (int i = 0; i < 2; i++) step(1'b0, 8'h00, 1'b1, "R9");
   endtask

   task automatic t_priority;
      set_mode(1'b0, 1'b0);
      step(1'b1, 8'h09, 1'b0, "R10");
      step(1'b1, 8'h04, 1'b1, "R10");
      set_mode(1'b1, 1'b0);
      step(1'b1, 8'h1A, 1'b1, "R10");
      set_mode(1'b0, 1'b1);
      step(1'b1, 8'h0E, 1'b1, "R10");
   endtask

   task automatic t_idle;
      set_mode(1'b0, 1'b0);
      step(1'b1, 8'h09, 1'b0, "R11");
      for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0, "R11");
      set_mode(1'b1, 1'b1);
      step(1'b0, 8'h00, 1'b0, "R11");
      set_mode(1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b0, "R11");
      step(1'b0, 8'h00, 1'b1, "R11");
   endtask

   initial begin
      t_reset();
      t_il_decode();
      t_split_decode();
      t_seq_il();
      t_seq_split();
      t_byte_split();
      t_byte_il();
      t_priority();
      t_idle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule